// File: doc/BRIEF.md
# Transposed-Form FIR Filter

This block is a four-tap finite impulse response filter. It computes the convolution of a stream of signed input samples with four signed coefficients. Each accepted sample goes to every coefficient multiplier in the same cycle. The partial sums then move through registers placed between the adders, toward the output end of the chain. Retiming the delays this way keeps the combinational path between registers to one multiply and one add, no matter how many taps the filter has.

A sample is accepted on any clock edge where `valid_i` is high. The filtered result appears on `y_o` one cycle later, with `valid_o` high. The coefficients come in on a static input bus. They are set before reset is released and are held constant while the filter is running. The accumulator is wide enough that no combination of inputs can overflow it.

Top module: `fir_xpose`

## Requirements
- R1: For each accepted sample x(n), the value on `y_o` equals the sum over i = 0..3 of h(i)·x(n-i), taken as signed two's-complement arithmetic. It appears one clock edge after the sample is accepted.
- R2: `valid_o` is high in exactly the cycle after an edge where `valid_i` was high. It is low after an edge where `valid_i` was low.
- R3: The output width is DATA_W + COEF_W + 2 (18 bits by default). The result never wraps, including the full-scale case of -128 at every tap with every coefficient at -128, which gives +65536.
- R4: Reset clears all history. After reset, the outputs include only the samples accepted since reset: older samples count as zero.
- R5: On an edge where `valid_i` is low, the sample on `x_i` is ignored. `y_o` and the stored history stay unchanged, so gaps in the stream do not change the sequence of results.
- R6: Coefficient h(k) sits in bits [8k+7:8k] of `coef_i`. h(0) weights the newest sample, so a unit impulse produces h(0), h(1), h(2), h(3) and then 0 on successive accepted samples.
- R7: While reset is held and before the first accepted sample, `y_o` is 0 and `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| coef_i | input | TAPS*COEF_W (32) | Static coefficients; h(k) in slice k |
| valid_i | input | 1 | Input sample qualifier |
| x_i | input | DATA_W (8) | Signed input sample |
| valid_o | output | 1 | Output qualifier, one cycle after valid_i |
| y_o | output | ACC_W (18) | Signed filter output |

## Verification
The assertions check three things on every cycle: the one-cycle relation between `valid_i` and `valid_o`, that every stage register holds its value when no sample is accepted, and that no adder in the chain produces a carry out of the accumulator width. Whether the retimed chain matches the direct convolution can only be shown by the bench's scenarios. These scenarios are the impulse that exposes the tap order, the step, streams with gaps, full-scale operands, resets in mid-stream, and a long random stream. Each one is compared against a model in the bench.

// File: rtl/fir_pkg.sv
package fir_pkg;
  function automatic int guard_bits(input int taps);
    return (taps > 1) ? $clog2(taps) : 1;
  endfunction
endpackage

// File: rtl/fir_mult.sv
module fir_mult #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  localparam int PROD_W = DATA_W + COEF_W
) (
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [COEF_W-1:0] b_i,
  output logic signed [PROD_W-1:0] p_o
);
  logic signed [PROD_W-1:0] a_ext, b_ext;
  assign a_ext = PROD_W'(a_i);
  assign b_ext = PROD_W'(b_i);
  assign p_o   = a_ext * b_ext;
endmodule

// File: rtl/fir_stage.sv
module fir_stage #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 18
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [COEF_W-1:0] coef_i,
  input  logic signed [ACC_W-1:0]  sum_i,
  output logic signed [ACC_W-1:0]  sum_o
);
  localparam int PROD_W = DATA_W + COEF_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext, sum_d;
  logic signed [ACC_W:0]    sum_wide;

  fir_mult #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_mult (
    .a_i(x_i), .b_i(coef_i), .p_o(prod)
  );

  assign prod_ext = ACC_W'(prod);
  assign sum_d    = prod_ext + sum_i;
  // one extra bit so a wrap of sum_d is visible to the checker
  assign sum_wide = (ACC_W+1)'(prod_ext) + (ACC_W+1)'(sum_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sum_o <= '0;
    else if (en_i) sum_o <= sum_d;
  end

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (sum_wide[ACC_W] == sum_wide[ACC_W-1]));

  assert_hold_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(sum_o));
endmodule

// File: rtl/fir_xpose.sv
module fir_xpose #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int TAPS   = 4,
  localparam int ACC_W = DATA_W + COEF_W + fir_pkg::guard_bits(TAPS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [TAPS*COEF_W-1:0]        coef_i,
  input  logic                          valid_i,
  input  logic signed [DATA_W-1:0]      x_i,
  output logic                          valid_o,
  output logic signed [ACC_W-1:0]       y_o
);
  // chain[k] is the register of stage k; chain[TAPS] is the zero feeding the far end
  logic signed [ACC_W-1:0] chain [TAPS+1];
  assign chain[TAPS] = '0;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic signed [COEF_W-1:0] coef_k;
    assign coef_k = coef_i[k*COEF_W +: COEF_W];

    fir_stage #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (valid_i),
      .x_i   (x_i),
      .coef_i(coef_k),
      .sum_i (chain[k+1]),
      .sum_o (chain[k])
    );
  end

  assign y_o = chain[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  assert_valid_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_valid_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  assert_out_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(y_o));
endmodule

// File: tb/fir_xpose_test.sv
`timescale 1ns/1ps
module fir_xpose_test;
  localparam int DATA_W = 8;
  localparam int COEF_W = 8;
  localparam int TAPS   = 4;
  localparam int ACC_W  = DATA_W + COEF_W + 2;

  logic                     clk = 1'b0;
  logic                     rst_ni = 1'b0;
  logic [TAPS*COEF_W-1:0]   coef_i = '0;
  logic                     valid_i = 1'b0;
  logic signed [DATA_W-1:0] x_i = '0;
  logic                     valid_o;
  logic signed [ACC_W-1:0]  y_o;

  int checks = 0;
  int failures = 0;
  int h [TAPS];
  int hist [TAPS];
  int last_y = 0;

  always #5 clk = ~clk;

  fir_xpose #(.DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .coef_i(coef_i), .valid_i(valid_i),
    .x_i(x_i), .valid_o(valid_o), .y_o(y_o)
  );

  function automatic int conv();
    int s = 0;
    for (int i = 0; i < TAPS; i++) s += h[i] * hist[i];
    return s;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_coefs(input int c0, input int c1, input int c2, input int c3);
    h[0] = c0; h[1] = c1; h[2] = c2; h[3] = c3;
    for (int k = 0; k < TAPS; k++) coef_i[k*COEF_W +: COEF_W] = COEF_W'(h[k]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; valid_i = 1'b0;
    for (int i = 0; i < TAPS; i++) hist[i] = 0;
    last_y = 0;
    repeat (2) @(negedge clk);
    check("R7 y in reset", int'(y_o), 0);
    check("R7 valid in reset", int'(valid_o), 0);
    rst_ni = 1'b1;
  endtask

  task automatic send(input string req, input int x, input bit v);
    @(negedge clk);
    valid_i = v;
    x_i = DATA_W'(x);
    @(posedge clk);
    #1;
    if (v) begin
      for (int i = TAPS-1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = x;
      last_y = conv();
    end
    check(req, int'(y_o), last_y);
    check("R2 valid_o", int'(valid_o), int'(v));
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    set_coefs(3, -5, 7, 2);
    do_reset();
    @(negedge clk);
    check("R7 y after reset", int'(y_o), 0);

    // R6 impulse: expect 3,-5,7,2,0
    send("R6 impulse", 1, 1'b1);
    send("R6 impulse", 0, 1'b1);
    send("R6 impulse", 0, 1'b1);
    send("R6 impulse", 0, 1'b1);
    send("R6 impulse", 0, 1'b1);

    // R1 step
    for (int i = 0; i < 6; i++) send("R1 step", 1, 1'b1);

    // R5 gaps: ignored samples carry large values
    send("R5 gap accept", 10, 1'b1);
    send("R5 gap ignored", 127, 1'b0);
    send("R5 gap ignored", -128, 1'b0);
    send("R5 gap accept", -20, 1'b1);
    send("R5 gap ignored", 99, 1'b0);
    send("R5 gap accept", 5, 1'b1);

    // R4 reset mid-stream: only the new sample counts
    do_reset();
    send("R4 fresh history", 5, 1'b1);
    send("R4 fresh history", -3, 1'b1);

    // R3 full-scale
    set_coefs(-128, -128, -128, -128);
    do_reset();
    for (int i = 0; i < 5; i++) send("R3 full scale", -128, 1'b1);
    set_coefs(127, -128, 127, -128);
    do_reset();
    for (int i = 0; i < 6; i++) send("R3 mixed extreme", (i % 2) ? 127 : -128, 1'b1);

    // R1 random stream with random gaps
    set_coefs(-17, 42, 99, -64);
    do_reset();
    for (int i = 0; i < 400; i++) begin
      int xr = int'($urandom_range(255)) - 128;
      bit vr = ($urandom_range(3) != 0);
      send("R1 random", xr, vr);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule